// File: doc/BRIEF.md
# Near-Region Row Cache Controller

This controller sits in front of a DRAM bank group whose arrays are split into a small fast region, close to the sense amplifiers, and a large slow region behind an isolation device. The fast region is used as a cache for rows whose home is in the slow region. For every row activation request the controller looks up a per-bank tag directory. A hit opens the near copy with short row timing. A miss opens the far row with long row timing. After a miss, a policy may migrate the far row into the near region by an in-bank copy that never touches the external data channel. If the evicted near copy was modified, it is first written back to its far home row.

Each bank has its own down-counter that holds off the next command to that bank for the row cycle of the last command issued to it. A refresh request isolates the far region, so it uses one fixed refresh time. It waits until every bank is idle and then blocks all banks for that time. While a migration or write-back sequence is in flight, the controller reports busy and accepts no request.

Top module: `near_cache_ctrl`

## Requirements
- R1: A request whose row has a valid near copy in its set is a hit. The set is the row modulo NEAR_SETS and the tag is the row divided by NEAR_SETS. A hit issues command code 1 (near activate) with that row and a slot value of set*2+way, and it increments hit_count by one.
- R2: A request whose row has no valid near copy is a miss. A miss issues command code 2 (far activate) with the requested row and slot 0, and it increments miss_count by one.
- R3: After a command, the next command to the same bank comes exactly T cycles later when it is already waiting. T is T_NEAR after a near activate, T_FAR after a far activate, T_WB after a write-back and T_COPY after a copy.
- R4: In demand mode (policy_benefit=0), every miss is followed by command code 4 (copy into near) for the same row into the chosen slot of its set.
- R5: In benefit mode (policy_benefit=1), a miss migrates only when it is the BENEFIT_THR-th miss in that bank and set since that set last migrated. The earlier misses are served from the far row with no copy.
- R6: The fill victim is the first invalid way, with way 0 before way 1. When both ways are valid, the victim is the least recently used way, where both hits and fills count as uses.
- R7: When the victim is valid and modified, command code 3 (write-back) for the victim's home row is issued T_FAR cycles after the far activate, and the copy follows T_WB cycles later. When the victim is clean or empty, there is no write-back and the copy follows the far activate after T_FAR cycles.
- R8: A write hit marks the near copy as modified. A migrated copy starts unmodified.
- R9: busy is high from the migrating far activate up to the copy, and req_ready stays low while busy is high.
- R10: A refresh request issues command code 5 once every bank counter has expired. It takes priority over requests and holds off every bank for T_REF cycles. It leaves the tag directory unchanged.
- R11: In reset and in the first cycle after it, no command is issued, busy is low and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Row activation request present |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request far row index |
| req_write | input | 1 | Request is a write |
| ref_req | input | 1 | Refresh wanted; hold until the refresh command appears |
| policy_benefit | input | 1 | 0 = demand migration, 1 = threshold migration |
| req_ready | output | 1 | Request accepted on this edge if req_valid |
| busy | output | 1 | Migration or write-back sequence in progress |
| cmd_valid | output | 1 | DRAM command issued this cycle |
| cmd_op | output | 3 | Command code (1 near act, 2 far act, 3 write-back, 4 copy, 5 refresh) |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Far row the command refers to |
| cmd_slot | output | SET_W+1 | Near slot, set*2+way |
| hit_count | output | STAT_W | Number of hits |
| miss_count | output | STAT_W | Number of misses |

## Verification
Corruption in the tag directory, such as a lost valid bit, a wrong tag or a stale LRU bit, first shows at the ports on the next request to the affected set. It appears as a far activate where a near activate was due, or as a copy into the wrong slot. A lost dirty bit shows up only when that line is evicted, as a missing write-back one far row cycle after the miss. A bad bank counter or sequencer state shifts the cycle of the next command, which the exact gap checks catch at that command.

// File: rtl/nsc_pkg.sv
// Shared types for the near-region row cache controller.
// Assumes: command codes are fixed because the command consumer decodes them.
package nsc_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_ACT_NEAR  = 3'd1,
        OP_ACT_FAR   = 3'd2,
        OP_WRITEBACK = 3'd3,
        OP_COPY_IN   = 3'd4,
        OP_REFRESH   = 3'd5
    } nsc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_COPY = 2'd2
    } nsc_state_e;

endpackage

// File: rtl/nsc_bank_timers.sv
// Per-bank command spacing counters.
// A single-bank load sets one counter. A global load (refresh) sets all counters.
// Each counter counts down to zero, and zero means the bank may take a command.
// Assumes: a single-bank load and a global load never occur in the same cycle.
module nsc_bank_timers #(
    parameter int NUM_BANKS = 2,
    parameter int TMR_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [BANK_W-1:0]    load_bank,
    input  logic [TMR_W-1:0]     load_val,
    input  logic                 load_all,
    input  logic [TMR_W-1:0]     all_val,
    output logic [NUM_BANKS-1:0] zero
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [TMR_W-1:0] cnt_q;

        // Load on a command, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (load_all) begin
                cnt_q <= all_val;
            end else if (load_en && (load_bank == BANK_W'(b))) begin
                cnt_q <= load_val;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - TMR_W'(1);
            end
        end

        assign zero[b] = (cnt_q == '0);
    end

endmodule

// File: rtl/nsc_tag_dir.sv
// Two-way tag directory per bank and near set.
// Each entry holds a valid bit, a modified bit and a far-row tag. Each set
// holds one LRU bit. Lookup is combinational, and updates occur at the clock edge.
// Assumes: touch and fill are never asserted in the same cycle.
module nsc_tag_dir #(
    parameter int NUM_BANKS = 2,
    parameter int NEAR_SETS = 4,
    parameter int TAG_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SET_W    = $clog2(NEAR_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic              lk_way,
    output logic              vic_way,
    output logic              vic_valid,
    output logic              vic_dirty,
    output logic [TAG_W-1:0]  vic_tag,
    input  logic              touch_en,
    input  logic              touch_way,
    input  logic              touch_dirty,
    input  logic              fill_en,
    input  logic [BANK_W-1:0] fill_bank,
    input  logic [SET_W-1:0]  fill_set,
    input  logic              fill_way,
    input  logic [TAG_W-1:0]  fill_tag
);

    localparam int WAYS = 2;

    logic [TAG_W-1:0] tag_q   [NUM_BANKS][NEAR_SETS][WAYS];
    logic             valid_q [NUM_BANKS][NEAR_SETS][WAYS];
    logic             dirty_q [NUM_BANKS][NEAR_SETS][WAYS];
    logic             lru_q   [NUM_BANKS][NEAR_SETS];

    logic hit0, hit1, v0, v1;

    // Tag compare and victim choice for the addressed set.
    always_comb begin
        v0        = valid_q[lk_bank][lk_set][0];
        v1        = valid_q[lk_bank][lk_set][1];
        hit0      = v0 && (tag_q[lk_bank][lk_set][0] == lk_tag);
        hit1      = v1 && (tag_q[lk_bank][lk_set][1] == lk_tag);
        lk_hit    = hit0 || hit1;
        lk_way    = !hit0 && hit1;
        vic_way   = !v0 ? 1'b0 : (!v1 ? 1'b1 : lru_q[lk_bank][lk_set]);
        vic_valid = valid_q[lk_bank][lk_set][vic_way];
        vic_dirty = dirty_q[lk_bank][lk_set][vic_way];
        vic_tag   = tag_q[lk_bank][lk_set][vic_way];
    end

    // Hits update LRU and modified state, and fills install a clean line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int s = 0; s < NEAR_SETS; s++) begin
                    lru_q[b][s] <= 1'b0;
                    for (int w = 0; w < WAYS; w++) begin
                        tag_q[b][s][w]   <= '0;
                        valid_q[b][s][w] <= 1'b0;
                        dirty_q[b][s][w] <= 1'b0;
                    end
                end
            end
        end else if (touch_en) begin
            lru_q[lk_bank][lk_set] <= ~touch_way;
            if (touch_dirty) begin
                dirty_q[lk_bank][lk_set][touch_way] <= 1'b1;
            end
        end else if (fill_en) begin
            tag_q[fill_bank][fill_set][fill_way]   <= fill_tag;
            valid_q[fill_bank][fill_set][fill_way] <= 1'b1;
            dirty_q[fill_bank][fill_set][fill_way] <= 1'b0;
            lru_q[fill_bank][fill_set]             <= ~fill_way;
        end
    end

endmodule

// File: rtl/nsc_policy.sv
// Migration decision for a miss.
// In demand mode every miss migrates. In benefit mode a per-bank, per-set
// counter counts misses, and the miss that reaches the threshold migrates and
// clears the counter.
// Assumes: THRESH >= 1.
module nsc_policy #(
    parameter int NUM_BANKS = 2,
    parameter int NEAR_SETS = 4,
    parameter int THRESH    = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SET_W    = $clog2(NEAR_SETS),
    localparam int CNT_W    = $clog2(THRESH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              benefit_mode,
    input  logic              ev_miss,
    input  logic [BANK_W-1:0] ev_bank,
    input  logic [SET_W-1:0]  ev_set,
    output logic              do_migrate
);

    logic [CNT_W-1:0] cnt_q [NUM_BANKS][NEAR_SETS];

    // Decide whether the current miss migrates.
    always_comb begin
        do_migrate = !benefit_mode || (cnt_q[ev_bank][ev_set] >= CNT_W'(THRESH - 1));
    end

    // Count benefit-mode misses per set, and clear the count on migration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int s = 0; s < NEAR_SETS; s++) begin
                    cnt_q[b][s] <= '0;
                end
            end
        end else if (ev_miss && benefit_mode) begin
            cnt_q[ev_bank][ev_set] <= do_migrate ? '0 : cnt_q[ev_bank][ev_set] + CNT_W'(1);
        end
    end

endmodule

// File: rtl/near_cache_ctrl.sv
// Near-region row cache controller, top level.
// Accepts row activation requests and looks up the tag directory. It issues
// near or far activates with per-bank spacing and sequences write-back and
// copy for migrations. Refresh is issued once every bank is idle.
// Assumes: NUM_BANKS and NEAR_SETS are powers of two of at least 2, and every
// timing parameter is at least 1 cycle.
module near_cache_ctrl
    import nsc_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int ROW_W       = 6,
    parameter int NEAR_SETS   = 4,
    parameter int STAT_W      = 16,
    parameter int T_NEAR      = 3,
    parameter int T_FAR       = 7,
    parameter int T_WB        = 4,
    parameter int T_COPY      = 2,
    parameter int T_REF       = 6,
    parameter int BENEFIT_THR = 3,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int SET_W      = $clog2(NEAR_SETS),
    localparam int TAG_W      = ROW_W - SET_W,
    localparam int SLOT_W     = SET_W + 1,
    localparam int T_MAX1     = (T_NEAR > T_FAR) ? T_NEAR : T_FAR,
    localparam int T_MAX2     = (T_WB > T_COPY) ? T_WB : T_COPY,
    localparam int T_MAX3     = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2,
    localparam int T_MAX      = (T_MAX3 > T_REF) ? T_MAX3 : T_REF,
    localparam int TMR_W      = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              ref_req,
    input  logic              policy_benefit,
    output logic              req_ready,
    output logic              busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [SLOT_W-1:0] cmd_slot,
    output logic [STAT_W-1:0] hit_count,
    output logic [STAT_W-1:0] miss_count
);

    nsc_state_e st_q;
    logic [BANK_W-1:0] mig_bank_q;
    logic [SET_W-1:0]  mig_set_q;
    logic              mig_way_q;
    logic [TAG_W-1:0]  mig_tag_q;
    logic [TAG_W-1:0]  vic_tag_q;

    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic [NUM_BANKS-1:0] tmr_zero;
    logic lk_hit, lk_way, vic_way, vic_valid, vic_dirty;
    logic [TAG_W-1:0] vic_tag;
    logic do_migrate;
    logic ref_go, acc, acc_hit, acc_miss, mig_issue, fill_en;
    logic load_en;
    logic [BANK_W-1:0] load_bank;
    logic [TMR_W-1:0]  load_val;

    // Split the request row into the near set and the tag.
    always_comb begin
        req_set = req_row[SET_W-1:0];
        req_tag = req_row[ROW_W-1:SET_W];
    end

    // Arbitration between refresh, requests and the migration sequence.
    always_comb begin
        ref_go    = (st_q == ST_IDLE) && ref_req && (&tmr_zero);
        req_ready = (st_q == ST_IDLE) && !ref_req && tmr_zero[req_bank];
        acc       = req_valid && req_ready;
        acc_hit   = acc && lk_hit;
        acc_miss  = acc && !lk_hit;
        mig_issue = (st_q != ST_IDLE) && tmr_zero[mig_bank_q];
        fill_en   = mig_issue && (st_q == ST_COPY);
        busy      = (st_q != ST_IDLE);
    end

    // Pick the spacing for the bank that receives a command.
    always_comb begin
        load_en   = acc || mig_issue;
        load_bank = acc ? req_bank : mig_bank_q;
        if (acc) begin
            load_val = lk_hit ? TMR_W'(T_NEAR - 1) : TMR_W'(T_FAR - 1);
        end else if (st_q == ST_WB) begin
            load_val = TMR_W'(T_WB - 1);
        end else begin
            load_val = TMR_W'(T_COPY - 1);
        end
    end

    nsc_bank_timers #(
        .NUM_BANKS (NUM_BANKS),
        .TMR_W     (TMR_W)
    ) u_timers (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_bank (load_bank),
        .load_val  (load_val),
        .load_all  (ref_go),
        .all_val   (TMR_W'(T_REF - 1)),
        .zero      (tmr_zero)
    );

    nsc_tag_dir #(
        .NUM_BANKS (NUM_BANKS),
        .NEAR_SETS (NEAR_SETS),
        .TAG_W     (TAG_W)
    ) u_dir (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_bank     (req_bank),
        .lk_set      (req_set),
        .lk_tag      (req_tag),
        .lk_hit      (lk_hit),
        .lk_way      (lk_way),
        .vic_way     (vic_way),
        .vic_valid   (vic_valid),
        .vic_dirty   (vic_dirty),
        .vic_tag     (vic_tag),
        .touch_en    (acc_hit),
        .touch_way   (lk_way),
        .touch_dirty (req_write),
        .fill_en     (fill_en),
        .fill_bank   (mig_bank_q),
        .fill_set    (mig_set_q),
        .fill_way    (mig_way_q),
        .fill_tag    (mig_tag_q)
    );

    nsc_policy #(
        .NUM_BANKS (NUM_BANKS),
        .NEAR_SETS (NEAR_SETS),
        .THRESH    (BENEFIT_THR)
    ) u_policy (
        .clk          (clk),
        .rst_n        (rst_n),
        .benefit_mode (policy_benefit),
        .ev_miss      (acc_miss),
        .ev_bank      (req_bank),
        .ev_set       (req_set),
        .do_migrate   (do_migrate)
    );

    // Sequencer: capture a migrating miss, then issue write-back and copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            mig_bank_q <= '0;
            mig_set_q  <= '0;
            mig_way_q  <= 1'b0;
            mig_tag_q  <= '0;
            vic_tag_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (acc_miss && do_migrate) begin
                        mig_bank_q <= req_bank;
                        mig_set_q  <= req_set;
                        mig_way_q  <= vic_way;
                        mig_tag_q  <= req_tag;
                        vic_tag_q  <= vic_tag;
                        st_q       <= (vic_valid && vic_dirty) ? ST_WB : ST_COPY;
                    end
                end
                ST_WB: begin
                    if (mig_issue) st_q <= ST_COPY;
                end
                default: begin
                    if (mig_issue) st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Registered command output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NOP;
            cmd_bank  <= '0;
            cmd_row   <= '0;
            cmd_slot  <= '0;
        end else begin
            cmd_valid <= ref_go || acc || mig_issue;
            if (ref_go) begin
                cmd_op   <= OP_REFRESH;
                cmd_bank <= '0;
                cmd_row  <= '0;
                cmd_slot <= '0;
            end else if (acc) begin
                cmd_op   <= lk_hit ? OP_ACT_NEAR : OP_ACT_FAR;
                cmd_bank <= req_bank;
                cmd_row  <= req_row;
                cmd_slot <= lk_hit ? {req_set, lk_way} : '0;
            end else if (mig_issue) begin
                cmd_op   <= (st_q == ST_WB) ? OP_WRITEBACK : OP_COPY_IN;
                cmd_bank <= mig_bank_q;
                cmd_row  <= (st_q == ST_WB) ? {vic_tag_q, mig_set_q} : {mig_tag_q, mig_set_q};
                cmd_slot <= {mig_set_q, mig_way_q};
            end else begin
                cmd_op   <= OP_NOP;
            end
        end
    end

    // Hit and miss statistics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (acc_hit)  hit_count  <= hit_count + STAT_W'(1);
            if (acc_miss) miss_count <= miss_count + STAT_W'(1);
        end
    end

endmodule

// File: rtl/nsc_checker.sv
// Port-level protocol checks for the near-region row cache controller.
// Assumes: command codes as in the brief.
module nsc_checker #(
    parameter int STAT_W = 16,
    parameter int T_REF  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              ref_req,
    input logic              busy,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [STAT_W-1:0] hit_count,
    input logic [STAT_W-1:0] miss_count
);

    assert_hit_counted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> (cmd_valid && cmd_op == 3'd1));

    assert_miss_counted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> (cmd_valid && cmd_op == 3'd2));

    assert_copy_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |-> ($past(busy) && !busy));

    assert_wb_inside_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |-> busy);

    assert_stall_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    assert_refresh_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !req_ready);

    assert_refresh_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((T_REF > 1) && cmd_valid && cmd_op == 3'd5) |-> (!req_ready && !busy));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !busy && hit_count == '0 && miss_count == '0));

endmodule

bind near_cache_ctrl nsc_checker #(
    .STAT_W (STAT_W),
    .T_REF  (T_REF)
) u_nsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .ref_req    (ref_req),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/near_cache_ctrl_bench.sv
// Scoreboard bench: the driver queues the expected commands, and a monitor
// compares them with the command port.
module near_cache_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int T_NEAR = 3;
    localparam int T_FAR  = 7;
    localparam int T_WB   = 4;
    localparam int T_COPY = 2;
    localparam int T_REF  = 6;
    localparam int WATCHDOG = 20000;

    localparam logic [2:0] C_NEAR = 3'd1, C_FAR = 3'd2, C_WB = 3'd3, C_COPY = 3'd4, C_REF = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [0:0] req_bank = '0;
    logic [5:0] req_row = '0;
    logic req_write = 1'b0;
    logic ref_req = 1'b0;
    logic policy_benefit = 1'b0;
    logic req_ready, busy, cmd_valid;
    logic [2:0] cmd_op;
    logic [0:0] cmd_bank;
    logic [5:0] cmd_row;
    logic [2:0] cmd_slot;
    logic [15:0] hit_count, miss_count;

    near_cache_ctrl #(
        .T_NEAR (T_NEAR), .T_FAR (T_FAR), .T_WB (T_WB),
        .T_COPY (T_COPY), .T_REF (T_REF)
    ) u_near_cache_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_bank (req_bank),
        .req_row (req_row), .req_write (req_write), .ref_req (ref_req),
        .policy_benefit (policy_benefit), .req_ready (req_ready), .busy (busy),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_bank (cmd_bank),
        .cmd_row (cmd_row), .cmd_slot (cmd_slot), .hit_count (hit_count),
        .miss_count (miss_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [2:0] op;
        int bank;
        int row;
        int slot;
        int gap;
        logic bsy;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_cmd(input logic [2:0] op, input int bank, input int row, input int slot,
                              input int gap, input logic bsy, input string req);
        exp_t e;
        e.op = op; e.bank = bank; e.row = row; e.slot = slot;
        e.gap = gap; e.bsy = bsy; e.req = req;
        exp_q.push_back(e);
    endtask

    // Present one request and hold it until the controller accepts it.
    task automatic do_req(input int bank, input int row, input bit wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = bank[0:0];
        req_row   = row[5:0];
        req_write = wr;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Monitor: pop one expected command for each issued command.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected command op", int'(cmd_op), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cmd_op == e.op, e.req, "op", int'(cmd_op), int'(e.op));
                check(int'(cmd_bank) == e.bank, e.req, "bank", int'(cmd_bank), e.bank);
                check(int'(cmd_row) == e.row, e.req, "row", int'(cmd_row), e.row);
                check(int'(cmd_slot) == e.slot, e.req, "slot", int'(cmd_slot), e.slot);
                check(busy == e.bsy, "R9", "busy", int'(busy), int'(e.bsy));
                if (e.gap >= 0)
                    check(cyc - last_cyc == e.gap, "R3", "gap", cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: quiet during reset
        check(!cmd_valid && !busy, "R11", "cmd_valid|busy in reset", int'(cmd_valid | busy), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid, "R11", "cmd_valid", int'(cmd_valid), 0);
        check(hit_count == 0 && miss_count == 0, "R11", "counters", int'(hit_count + miss_count), 0);
        check(req_ready, "R11", "req_ready", int'(req_ready), 1);

        // R2 R4 R6: cold miss fills way 0 of set 1
        expect_cmd(C_FAR, 0, 5, 0, -1, 1'b1, "R2");
        expect_cmd(C_COPY, 0, 5, 2, T_FAR, 1'b0, "R4");
        do_req(0, 5, 1'b0);
        // R1: read hit
        expect_cmd(C_NEAR, 0, 5, 2, T_COPY, 1'b0, "R1");
        do_req(0, 5, 1'b0);
        // R8: write hit marks line modified
        expect_cmd(C_NEAR, 0, 5, 2, T_NEAR, 1'b0, "R8");
        do_req(0, 5, 1'b1);
        // R6: second way used while empty
        expect_cmd(C_FAR, 0, 9, 0, T_NEAR, 1'b1, "R2");
        expect_cmd(C_COPY, 0, 9, 3, T_FAR, 1'b0, "R6");
        do_req(0, 9, 1'b0);
        // R7: LRU victim row 5 is modified, so write-back precedes the copy
        expect_cmd(C_FAR, 0, 13, 0, T_COPY, 1'b1, "R2");
        expect_cmd(C_WB, 0, 5, 2, T_FAR, 1'b1, "R7");
        expect_cmd(C_COPY, 0, 13, 2, T_WB, 1'b0, "R7");
        do_req(0, 13, 1'b0);
        // R6: hit on way 1 makes way 0 the LRU way
        expect_cmd(C_NEAR, 0, 9, 3, T_COPY, 1'b0, "R6");
        do_req(0, 9, 1'b0);
        // R7: clean victim, no write-back
        expect_cmd(C_FAR, 0, 17, 0, T_NEAR, 1'b1, "R7");
        expect_cmd(C_COPY, 0, 17, 2, T_FAR, 1'b0, "R7");
        do_req(0, 17, 1'b0);
        // R9: other bank waits for the sequence end; bank 1 has its own directory
        expect_cmd(C_FAR, 1, 5, 0, 1, 1'b1, "R9");
        expect_cmd(C_COPY, 1, 5, 2, T_FAR, 1'b0, "R4");
        do_req(1, 5, 1'b0);
        expect_cmd(C_NEAR, 0, 17, 2, 1, 1'b0, "R1");
        do_req(0, 17, 1'b0);

        // R5: benefit mode migrates on the third miss in the set
        policy_benefit = 1'b1;
        expect_cmd(C_FAR, 0, 2, 0, T_NEAR, 1'b0, "R5");
        do_req(0, 2, 1'b0);
        expect_cmd(C_FAR, 0, 2, 0, T_FAR, 1'b0, "R5");
        do_req(0, 2, 1'b0);
        expect_cmd(C_FAR, 0, 2, 0, T_FAR, 1'b1, "R5");
        expect_cmd(C_COPY, 0, 2, 4, T_FAR, 1'b0, "R5");
        do_req(0, 2, 1'b0);
        expect_cmd(C_NEAR, 0, 2, 4, T_COPY, 1'b0, "R5");
        do_req(0, 2, 1'b0);

        // R10: refresh after the bank drains, then blocks for T_REF, directory kept
        expect_cmd(C_REF, 0, 0, 0, T_NEAR, 1'b0, "R10");
        @(negedge clk);
        ref_req = 1'b1;
        while (!(cmd_valid && cmd_op == C_REF)) @(negedge clk);
        ref_req = 1'b0;
        expect_cmd(C_NEAR, 0, 2, 4, T_REF, 1'b0, "R10");
        do_req(0, 2, 1'b0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (T_FAR + 2) @(negedge clk);
        check(hit_count == 16'd6, "R1", "hit_count", int'(hit_count), 6);
        check(miss_count == 16'd8, "R2", "miss_count", int'(miss_count), 8);
        check(!busy && req_ready, "R9", "idle at end", int'(busy), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog actual %0d expected %0d", WATCHDOG, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule